// File: doc/BRIEF.md
# Composite Sync Vertical Extractor

This block recovers a vertical sync indication from two composite sync sources, working in the crystal clock domain. One source is a sync-on-green composite signal and the other is a separate composite sync pin. Both arrive asynchronously. Each is retimed through a flop synchronizer and may be inverted under register control. A pulse-width counter then measures how long the conditioned signal stays at its active level. Narrow horizontal pulses end before the count gets far. Broad vertical serration pulses push the count past a programmable 12-bit threshold, and that raises the extracted vertical sync for that source.

Each source has its own threshold and its own polarity control. Both sit in a small byte-wide configuration space. The two sources run fully independently, and each drives its own extracted output. A threshold of zero turns extraction off for that source.

Top module: `csync_vext`

## Requirements
- R1: The two sources are independent. Activity on one pin never asserts the other source's output.
- R2: After reset both outputs are low. Both invert bits are 0. Each threshold reads 0x80 at its low-byte address and 0x00 at its high-byte address.
- R3: Register map, offered through a write strobe and a combinational read. Address 0 holds control: bit 0 inverts the sync-on-green input and bit 1 inverts the composite sync pin. Addresses 1 and 2 hold the sync-on-green threshold bits [7:0] and [11:8]. Addresses 3 and 4 hold the same fields for the composite sync pin. A write takes effect at the clock edge on which it is strobed. Unused bits, and addresses 5 to 7, read as zero.
- R4: Suppose a pin is first sampled at its active level on clock edge E0. The output for that source then goes high right after edge E(THR+1), where THR is that source's threshold.
- R5: A pin held active for exactly L consecutive edges keeps its output high for L-THR+1 cycles. If L is less than THR, the output never goes high.
- R6: With the invert bit at 0 the active level is low. With the invert bit at 1 the active level is high.
- R7: A threshold of zero keeps that source's output low, whatever the pin does.
- R8: The width counter saturates at 4095 rather than wrapping. With THR = 4095, a pulse longer than 4096 edges keeps the output high until the pulse ends.
- R9: All 12 threshold bits are used. A threshold above 255 delays assertion to THR+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sog_pin | input | 1 | Asynchronous sync-on-green composite input |
| csync_pin | input | 1 | Asynchronous composite sync input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| vs_sog | output | 1 | Vertical sync extracted from sync-on-green |
| vs_csync | output | 1 | Vertical sync extracted from composite sync pin |

## Verification
The extractor is driven with active pulses of chosen lengths and thresholds. A pulse well above the threshold shows the exact rise edge and the high duration. A pulse just below the threshold must produce nothing, which separates a greater-or-equal compare from a strict one. A threshold above 255 proves that the high nibble is used. Further runs use an inverted polarity, a zero threshold, and a pulse longer than the counter range. The last of these separates saturation from wrap-around. Every run also watches the other source's output to confirm that the two sources are independent.

// File: rtl/csvx_pkg.sv
package csvx_pkg;
   localparam int NSRC   = 2;
   localparam int REG_AW = 3;
   localparam int SRC_SOG   = 0;
   localparam int SRC_CSYNC = 1;

   typedef enum logic [REG_AW-1:0] {
      A_CTRL     = 3'd0,
      A_SOG_LO   = 3'd1,
      A_SOG_HI   = 3'd2,
      A_CSYNC_LO = 3'd3,
      A_CSYNC_HI = 3'd4
   } cfg_addr_e;

   function automatic logic [REG_AW-1:0] lo_addr(input int s);
      return REG_AW'(1 + 2 * s);
   endfunction

   function automatic logic [REG_AW-1:0] hi_addr(input int s);
      return REG_AW'(2 + 2 * s);
   endfunction
endpackage

// File: rtl/csvx_sync.sv
module csvx_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("csvx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csvx_regs.sv
module csvx_regs
   import csvx_pkg::*;
#(
   parameter int              THR_W   = 12,
   parameter logic [THR_W-1:0] THR_RST = 12'h080
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [REG_AW-1:0]           addr,
   input  logic [7:0]                  wdata,
   output logic [7:0]                  rdata,
   output logic [NSRC-1:0]             inv,
   output logic [NSRC-1:0][THR_W-1:0]  thr
);
   localparam int HI_W = THR_W - 8;

   logic [NSRC-1:0]           inv_q;
   logic [NSRC-1:0][7:0]      lo_q;
   logic [NSRC-1:0][HI_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      inv_q <= '0;
      else if (we && addr == A_CTRL)   inv_q <= wdata[NSRC-1:0];
   end

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_thr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q[s] <= THR_RST[7:0];
               hi_q[s] <= THR_RST[THR_W-1:8];
            end else if (we) begin
               if (addr == lo_addr(s)) lo_q[s] <= wdata;
               if (addr == hi_addr(s)) hi_q[s] <= wdata[HI_W-1:0];
            end
         end
         assign thr[s] = {hi_q[s], lo_q[s]};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == A_CTRL) rdata[NSRC-1:0] = inv_q;
      for (int s = 0; s < NSRC; s++) begin
         if (addr == lo_addr(s)) rdata = lo_q[s];
         if (addr == hi_addr(s)) rdata = {{(8-HI_W){1'b0}}, hi_q[s]};
      end
   end

   assign inv = inv_q;
endmodule

// File: rtl/csvx_det.sv
module csvx_det #(
   parameter int THR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [THR_W-1:0] thr,
   output logic [THR_W-1:0] cnt,
   output logic             vs
);
   localparam logic [THR_W-1:0] CNT_MAX = '1;

   logic [THR_W-1:0] cnt_q;
   logic [THR_W-1:0] cnt_nx;
   logic             vs_q;

   always_comb begin
      if (!active)               cnt_nx = '0;
      else if (cnt_q == CNT_MAX) cnt_nx = cnt_q;
      else                       cnt_nx = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         vs_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_nx;
         vs_q  <= (thr != '0) && (cnt_nx >= thr);
      end
   end

   assign cnt = cnt_q;
   assign vs  = vs_q;
endmodule

// File: rtl/csync_vext.sv
module csync_vext
   import csvx_pkg::*;
#(
   parameter int               THR_W       = 12,
   parameter int               SYNC_STAGES = 2,
   parameter logic [THR_W-1:0] THR_RST     = 12'h080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sog_pin,
   input  logic              csync_pin,
   input  logic              cfg_we,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              vs_sog,
   output logic              vs_csync
);
   generate
      if (THR_W < 9 || THR_W > 16) begin : g_bad_w
         $error("csync_vext: THR_W must lie in 9..16");
      end
   endgenerate

   logic [NSRC-1:0]            pin_w;
   logic [NSRC-1:0]            sync_w;
   logic [NSRC-1:0]            act_w;
   logic [NSRC-1:0]            inv_w;
   logic [NSRC-1:0]            vs_w;
   logic [NSRC-1:0][THR_W-1:0] thr_w;
   logic [NSRC-1:0][THR_W-1:0] cnt_w;

   assign pin_w[SRC_SOG]   = sog_pin;
   assign pin_w[SRC_CSYNC] = csync_pin;

   csvx_regs #(.THR_W(THR_W), .THR_RST(THR_RST)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .inv   (inv_w),
      .thr   (thr_w)
   );

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         csvx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_w[s]),
            .q     (sync_w[s])
         );

         // conditioned level is low when active
         assign act_w[s] = ~(sync_w[s] ^ inv_w[s]);

         csvx_det #(.THR_W(THR_W)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (act_w[s]),
            .thr    (thr_w[s]),
            .cnt    (cnt_w[s]),
            .vs     (vs_w[s])
         );
      end
   endgenerate

   assign vs_sog   = vs_w[SRC_SOG];
   assign vs_csync = vs_w[SRC_CSYNC];
endmodule

// File: rtl/csvx_chk.sv
module csvx_chk
   import csvx_pkg::*;
#(
   parameter int THR_W = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NSRC-1:0]            act,
   input logic [NSRC-1:0][THR_W-1:0] thr,
   input logic [NSRC-1:0][THR_W-1:0] cnt,
   input logic [NSRC-1:0]            vs,
   input logic [REG_AW-1:0]          addr,
   input logic [7:0]                 rdata
);
   localparam logic [THR_W-1:0] CMAX = '1;
   localparam int HI_W = THR_W - 8;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_a
         AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (thr[s] == '0) |=> !vs[s]);                                   // R7
         AST_VS_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !act[s] |=> !vs[s]);                                          // R5
         AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !act[s] |=> (cnt[s] == '0));                                  // R5
         AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
            (act[s] && cnt[s] == CMAX) |=> (cnt[s] == CMAX));             // R8
         AST_RISE_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(vs[s]) |-> (cnt[s] >= $past(thr[s])));                  // R4
         AST_HI_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == hi_addr(s)) |-> (rdata[7:HI_W] == '0));             // R3
      end
   endgenerate

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr > A_CSYNC_HI) |-> (rdata == 8'h00));                          // R3
   AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_CTRL) |-> (rdata[7:NSRC] == '0));                        // R3
endmodule

bind csync_vext csvx_chk #(.THR_W(THR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .act   (act_w),
   .thr   (thr_w),
   .cnt   (cnt_w),
   .vs    (vs_w),
   .addr  (cfg_addr),
   .rdata (cfg_rdata)
);

// File: tb/csync_vext_tb.sv
module csync_vext_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sog_pin = 1'b1;
   logic       csync_pin = 1'b1;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       vs_sog, vs_csync;

   int n_vec = 0;
   int n_bad = 0;
   logic [1:0] inv_b = 2'b00;

   always #5 clk = ~clk;

   csync_vext u_dut (
      .clk(clk), .rst_n(rst_n), .sog_pin(sog_pin), .csync_pin(csync_pin),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .vs_sog(vs_sog), .vs_csync(vs_csync)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input int a, input int exp);
      @(negedge clk);
      cfg_addr = 3'(a);
      #1;
      check(req, int'(cfg_rdata), exp);
   endtask

   task automatic set_pin(input int s, input logic v);
      if (s == 0) sog_pin = v; else csync_pin = v;
   endtask

   function automatic logic vs_of(input int s);
      return (s == 0) ? vs_sog : vs_csync;
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Drive an active pulse spanning L edges on source s and measure outputs.
   task automatic pulse(input int s, input int L, input int thr, input string req);
      int first = -1;
      int hi = 0;
      int other = 0;
      int exp_hi;
      logic act_lvl = inv_b[s];
      @(negedge clk);
      set_pin(s, act_lvl);
      for (int j = 0; j < L + 5; j++) begin
         @(negedge clk);
         if (vs_of(s)) begin
            if (first < 0) first = j;
            hi++;
         end
         if (vs_of(1 - s)) other++;
         if (j == L - 1) set_pin(s, ~act_lvl);
      end
      idle(4);
      exp_hi = (thr != 0 && L >= thr) ? (L - thr + 1) : 0;
      check({req, " high cycles"}, hi, exp_hi);
      if (exp_hi > 0) check({req, " R4 rise edge"}, first, thr + 1);
      check("R1 other source quiet", other, 0);
   endtask

   task automatic t_reset;
      check("R2 vs_sog reset", int'(vs_sog), 0);
      check("R2 vs_csync reset", int'(vs_csync), 0);
      rd_check("R2 ctrl", 0, 0);
      rd_check("R2 sog lo", 1, 8'h80);
      rd_check("R2 sog hi", 2, 0);
      rd_check("R2 csync lo", 3, 8'h80);
      rd_check("R2 csync hi", 4, 0);
   endtask

   task automatic t_regs;
      wr(2, 8'hFF);
      rd_check("R3 sog hi reserved", 2, 8'h0F);
      wr(2, 8'h00);
      wr(0, 8'hFC);
      rd_check("R3 ctrl reserved", 0, 0);
      wr(7, 8'hFF);
      rd_check("R3 unmapped", 7, 0);
      rd_check("R3 unmapped5", 5, 0);
   endtask

   task automatic t_basic;
      pulse(0, 200, 128, "R4 R5 default sog");
      pulse(0, 127, 128, "R5 short by one");
      pulse(0, 128, 128, "R5 exactly thr");
   endtask

   task automatic t_csync;
      wr(3, 8'h23);
      wr(4, 8'h01);
      rd_check("R3 csync lo", 3, 8'h23);
      rd_check("R3 csync hi", 4, 8'h01);
      pulse(1, 300, 291, "R9 wide thr csync");
   endtask

   task automatic t_invert;
      wr(0, 8'h01);
      inv_b = 2'b01;
      sog_pin = 1'b0;
      idle(4);
      check("R6 no false vs after invert", int'(vs_sog), 0);
      pulse(0, 150, 128, "R6 inverted sog");
      wr(0, 8'h00);
      inv_b = 2'b00;
      sog_pin = 1'b1;
      idle(4);
   endtask

   task automatic t_zero;
      wr(3, 0);
      wr(4, 0);
      pulse(1, 50, 0, "R7 zero thr");
   endtask

   task automatic t_sat;
      wr(1, 8'hFF);
      wr(2, 8'h0F);
      pulse(0, 5000, 4095, "R8 saturation");
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(3);
      t_reset;
      t_regs;
      t_basic;
      t_csync;
      t_invert;
      t_zero;
      t_sat;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule